// File: doc/BRIEF.md
# Windowed Watchdog Timer with Feed Sequence

This block is a register-mapped watchdog. A 24-bit down-counter steps once per pulse on a tick-enable input. Software reloads it from a programmable constant by writing a two-byte code, 0xAA and then 0x55, to a write-only feed register. The counter does not move until the enable bit is set and a first good feed arrives. From then on the timer cannot be stopped except by a block reset.

Two kinds of trouble are reported through a time-out flag:
- the counter expiring;
- a bad feed, which is a broken feed code or a good feed that arrives while the counter is still above the window value.

A warning flag marks the counter reaching a separate compare value. Depending on a sticky reset-enable bit, a time-out either raises the interrupt output or issues a one-cycle chip-reset request. A sticky protect bit restricts when the reload constant may be changed. A sticky lock bit, once armed by a good feed, drives an oscillator-lock status output.

The register bus is synchronous: a write takes effect at the clock edge where the write enable is high. Read data is a combinational function of the address.

Top module: `guard_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and the irq, rst_req and osc_locked outputs are low.
- R2: A feed write of 0xAA (low byte, offset 0x08) followed by a feed write of 0x55 is a good feed. It loads the counter (read at offset 0x0C) from the constant (offset 0x04). If the enable bit (bit 0 at offset 0x00) is 1, it also starts the timer. While running, the counter drops by exactly one per tick_en cycle.
- R3: Before the timer has started, ticks leave the counter unchanged. Once the timer has started, writing 0 to the enable bit does not stop it, and the enable bit reads 1.
- R4: A tick that takes the counter from 1 to 0 sets the time-out flag (bit 2 at offset 0x00). With reset-enable (bit 1) at 0, irq goes high and rst_req stays low.
- R5: Reset-enable can be set by software but not cleared. While it is 1, every event that sets the time-out flag produces exactly one rst_req cycle, starting in the cycle after that event's clock edge, and the time-out flag does not drive irq.
- R6: A tick that takes the counter to the warning compare value (10 bits at offset 0x14, zero-extended) sets the warning flag (bit 3 at offset 0x00) and raises irq.
- R7: Writing 1 to bit 2 or bit 3 of offset 0x00 clears that flag. Writing 0 leaves it unchanged. If a set event and a clear happen in the same cycle, the set wins.
- R8: An 0xAA feed write followed by a feed write of any other value sets the time-out flag and leaves the counter unchanged. A first feed write other than 0xAA is ignored.
- R9: A good feed while the timer runs and the counter exceeds the window value (offset 0x18) sets the time-out flag. The counter is still reloaded.
- R10: The protect bit (bit 4) and the lock bit (bit 5) can be set but not cleared by software. osc_locked rises on the first good feed made while the lock bit is 1, and never before.
- R11: With protect set, a write to the constant is accepted only if the counter is below both the warning value and the window value. Otherwise the constant keeps its value and the time-out flag is set.
- R12: Writes to the value register (offset 0x0C) have no effect, and the feed register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Counter step enable, one step per high cycle |
| irq | output | 1 | Interrupt: warning flag, or time-out flag while reset-enable is 0 |
| rst_req | output | 1 | One-cycle chip-reset request |
| osc_locked | output | 1 | Oscillator-lock status, armed by a good feed with the lock bit set |

## Verification
The counting path is exercised with random reload constants, random tick counts short of expiry and random warning values, all from a fixed seed. Comparing the remaining count with constant minus ticks separates a correct one-per-tick decrement from skipped or doubled steps. Checking the warning flag against whether the count passed the compare value separates an equality compare from an off-by-one or a relational one.

A directed sequence covers the remaining cases in turn:
- a broken feed code and an out-of-window feed, which both set the flag while reloading differently;
- a protected constant write attempted above and then below both thresholds;
- attempts to clear each sticky bit;
- expiry with reset-enable at 0 and at 1, which separates the interrupt path from the single-cycle reset request.

// File: rtl/guard_timer_pkg.sv
// Package: shared constants and types for the windowed watchdog.
// Assumes byte addressing on an 8-bit register address.
package guard_timer_pkg;
    localparam int CNT_W  = 24;
    localparam int WARN_W = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] A_CONST = 8'h04;
    localparam logic [ADDR_W-1:0] A_FEED  = 8'h08;
    localparam logic [ADDR_W-1:0] A_VALUE = 8'h0C;
    localparam logic [ADDR_W-1:0] A_WARN  = 8'h14;
    localparam logic [ADDR_W-1:0] A_WIN   = 8'h18;

    localparam logic [7:0] FEED_FIRST  = 8'hAA;
    localparam logic [7:0] FEED_SECOND = 8'h55;

    localparam int B_EN    = 0;
    localparam int B_RSTEN = 1;
    localparam int B_TOF   = 2;
    localparam int B_WINT  = 3;
    localparam int B_PROT  = 4;
    localparam int B_LOCK  = 5;
    localparam int MODE_W  = 6;

    typedef enum logic {FS_IDLE, FS_ARMED} feed_state_e;
endpackage

// File: rtl/guard_timer_feed.sv
// Feed sequencer: watches writes to the feed register and reports a good
// two-byte code or a broken one. Assumes one write per cycle at most.
module guard_timer_feed
    import guard_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       feed_wr,
    input  logic [7:0] feed_byte,
    output logic       feed_ok,
    output logic       feed_bad
);
    feed_state_e state_q, state_d;

    // Decode the current feed write against the sequencer state.
    always_comb begin
        state_d  = state_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        if (feed_wr) begin
            case (state_q)
                FS_IDLE: begin
                    if (feed_byte == FEED_FIRST) state_d = FS_ARMED;
                end
                FS_ARMED: begin
                    state_d = FS_IDLE;
                    if (feed_byte == FEED_SECOND) feed_ok  = 1'b1;
                    else                          feed_bad = 1'b1;
                end
                default: state_d = FS_IDLE;
            endcase
        end
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    AST_FEED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_ok || feed_bad) |=> (state_q == FS_IDLE)); // R2
    AST_BAD_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        feed_bad |-> (state_q == FS_ARMED)); // R8
endmodule

// File: rtl/guard_timer_count.sv
// Down-counter: reloads on a good feed, steps on tick_en while running,
// and reports expiry (1 -> 0) and arrival at the warning value.
// Assumes the reload request has priority over a tick in the same cycle.
module guard_timer_count
    import guard_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick_en,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] warn_cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             warn_hit
);
    logic             step;
    logic [CNT_W-1:0] cnt_next;

    // Work out whether this cycle steps the counter and where it lands.
    always_comb begin
        step     = running && tick_en && !reload && (cnt != '0);
        cnt_next = cnt - 1'b1;
        expire   = step && (cnt_next == '0);
        warn_hit = step && (cnt_next == warn_cmp);
    end

    // Counter register: reload first, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (reload) cnt <= reload_val;
        else if (step)   cnt <= cnt_next;
    end

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload) |=> $stable(cnt)); // R3
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_RELOAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == $past(reload_val))); // R2
endmodule

// File: rtl/guard_timer_ctrl.sv
// Control registers: mode bits (sticky and write-1-to-clear), reload
// constant with protection, warning and window values, error gathering,
// and the irq, reset-request and lock outputs.
// Assumes register writes arrive as single-cycle strobes from the decoder.
module guard_timer_ctrl
    import guard_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_const,
    input  logic              wr_warn,
    input  logic              wr_win,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              feed_ok,
    input  logic              feed_bad,
    input  logic              expire,
    input  logic              warn_hit,
    input  logic [CNT_W-1:0]  cnt,
    output logic [MODE_W-1:0] mode_rd,
    output logic [CNT_W-1:0]  const_q,
    output logic [WARN_W-1:0] warn_q,
    output logic [CNT_W-1:0]  win_q,
    output logic              running,
    output logic              irq,
    output logic              rst_req,
    output logic              osc_locked
);
    logic en_q, rsten_q, tof_q, wint_q, prot_q, lock_q;
    logic win_err, prot_err, tof_set;
    logic [CNT_W-1:0] warn_ext;

    // Gather the events that set the time-out flag.
    always_comb begin
        warn_ext = {{(CNT_W-WARN_W){1'b0}}, warn_q};
        win_err  = feed_ok && running && (cnt > win_q);
        prot_err = wr_const && prot_q && !((cnt < warn_ext) && (cnt < win_q));
        tof_set  = expire || feed_bad || win_err || prot_err;
    end

    // Enable bit: writable until the timer starts; running is permanent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            running <= 1'b0;
        end else begin
            if (wr_mode && !running) en_q <= wdata[B_EN];
            if (feed_ok && en_q)     running <= 1'b1;
        end
    end

    // Sticky set-only bits: reset-enable, protect, lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsten_q <= 1'b0;
            prot_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else if (wr_mode) begin
            if (wdata[B_RSTEN]) rsten_q <= 1'b1;
            if (wdata[B_PROT])  prot_q  <= 1'b1;
            if (wdata[B_LOCK])  lock_q  <= 1'b1;
        end
    end

    // Status flags: hardware set wins over a software write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tof_q  <= 1'b0;
            wint_q <= 1'b0;
        end else begin
            if (tof_set)                     tof_q <= 1'b1;
            else if (wr_mode && wdata[B_TOF]) tof_q <= 1'b0;
            if (warn_hit)                      wint_q <= 1'b1;
            else if (wr_mode && wdata[B_WINT]) wint_q <= 1'b0;
        end
    end

    // Value registers; a protected constant write may be refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            const_q <= '0;
            warn_q  <= '0;
            win_q   <= '0;
        end else begin
            if (wr_const && !prot_err) const_q <= wdata;
            if (wr_warn)               warn_q  <= wdata[WARN_W-1:0];
            if (wr_win)                win_q   <= wdata;
        end
    end

    // Reset request: one cycle per time-out while reset-enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= tof_set && rsten_q && !rst_req;
    end

    // Oscillator lock: armed by a good feed once the lock bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                 osc_locked <= 1'b0;
        else if (feed_ok && lock_q) osc_locked <= 1'b1;
    end

    // Read image and interrupt output.
    always_comb begin
        mode_rd         = '0;
        mode_rd[B_EN]    = en_q | running;
        mode_rd[B_RSTEN] = rsten_q;
        mode_rd[B_TOF]   = tof_q;
        mode_rd[B_WINT]  = wint_q;
        mode_rd[B_PROT]  = prot_q;
        mode_rd[B_LOCK]  = lock_q;
        irq = wint_q | (tof_q & ~rsten_q);
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R3
    AST_RSTEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rsten_q |=> rsten_q); // R5
    AST_RSTREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R5
    AST_RSTREQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (tof_q && rsten_q)); // R5
    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q |=> prot_q); // R10
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R10
    AST_LOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        osc_locked |-> lock_q); // R10
    AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tof_q); // R4
    AST_CONST_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_const && prot_q && !((cnt < warn_ext) && (cnt < win_q))) |=> ($stable(const_q) && tof_q)); // R11
endmodule

// File: rtl/guard_timer.sv
// Top level of the windowed watchdog: register decode, read mux, and the
// feed, counter and control sub-blocks. Assumes synchronous single-cycle
// writes and a combinational read path.
module guard_timer
    import guard_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq,
    output logic              rst_req,
    output logic              osc_locked
);
    logic wr_mode, wr_const, wr_feed, wr_warn, wr_win;
    logic feed_ok, feed_bad, expire, warn_hit, running;
    logic [MODE_W-1:0] mode_rd;
    logic [CNT_W-1:0]  const_q, win_q, cnt, warn_ext;
    logic [WARN_W-1:0] warn_q;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

    // Write strobe decode.
    always_comb begin
        wr_mode  = bus_we && (bus_addr == A_MODE);
        wr_const = bus_we && (bus_addr == A_CONST);
        wr_feed  = bus_we && (bus_addr == A_FEED);
        wr_warn  = bus_we && (bus_addr == A_WARN);
        wr_win   = bus_we && (bus_addr == A_WIN);
        warn_ext = {{(CNT_W-WARN_W){1'b0}}, warn_q};
    end

    // Read mux; feed and unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:  bus_rdata[MODE_W-1:0] = mode_rd;
            A_CONST: bus_rdata[CNT_W-1:0]  = const_q;
            A_VALUE: bus_rdata[CNT_W-1:0]  = cnt;
            A_WARN:  bus_rdata[WARN_W-1:0] = warn_q;
            A_WIN:   bus_rdata[CNT_W-1:0]  = win_q;
            default: bus_rdata = '0;
        endcase
    end

    guard_timer_feed u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .feed_wr  (wr_feed),
        .feed_byte(bus_wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    guard_timer_count u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .tick_en   (tick_en),
        .reload    (feed_ok),
        .reload_val(const_q),
        .warn_cmp  (warn_ext),
        .cnt       (cnt),
        .expire    (expire),
        .warn_hit  (warn_hit)
    );

    guard_timer_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_mode),
        .wr_const  (wr_const),
        .wr_warn   (wr_warn),
        .wr_win    (wr_win),
        .wdata     (bus_wdata[CNT_W-1:0]),
        .feed_ok   (feed_ok),
        .feed_bad  (feed_bad),
        .expire    (expire),
        .warn_hit  (warn_hit),
        .cnt       (cnt),
        .mode_rd   (mode_rd),
        .const_q   (const_q),
        .warn_q    (warn_q),
        .win_q     (win_q),
        .running   (running),
        .irq       (irq),
        .rst_req   (rst_req),
        .osc_locked(osc_locked)
    );

    AST_VALUE_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_VALUE && !running && !feed_ok) |=> $stable(cnt)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !feed_ok) |=> !rst_req || $past(rst_req) == 1'b0); // R1
endmodule

// File: tb/guard_timer_bench.sv
`timescale 1ns/1ps
module guard_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq, rst_req, osc_locked;

    int total = 0;
    int bad = 0;
    int req_cycles = 0;
    int req_run = 0;
    int req_max = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    guard_timer u_guard_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .irq(irq), .rst_req(rst_req), .osc_locked(osc_locked)
    );

    // Reset-request monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_req) begin
            req_cycles++;
            req_run++;
            if (req_run > req_max) req_max = req_run;
        end else begin
            req_run = 0;
        end
    end

    function automatic logic [31:0] exp_cnt(input int tc, input int k);
        return 32'(tc - k);
    endfunction

    function automatic logic exp_wint(input int tc, input int k, input int w);
        return (w < tc) && (tc - k <= w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic feed();
        wr(8'h08, 32'hAA);
        wr(8'h08, 32'h55);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int mark;
        void'($urandom(32'd4711));
        do_reset();

        // R1: reset state
        rd(8'h00, v); chk("R1 mode", v, 0);
        rd(8'h04, v); chk("R1 const", v, 0);
        rd(8'h0C, v); chk("R1 value", v, 0);
        rd(8'h14, v); chk("R1 warn", v, 0);
        rd(8'h18, v); chk("R1 window", v, 0);
        chk("R1 outputs", {29'b0, irq, rst_req, osc_locked}, 0);

        // R3: stopped counter ignores ticks
        wr(8'h04, 20); wr(8'h18, 32'hFFFFFF);
        ticks(3);
        rd(8'h0C, v); chk("R3 stopped", v, 0);

        // R2: good feed loads and starts; one step per tick
        wr(8'h00, 32'h1);
        feed();
        rd(8'h0C, v); chk("R2 reload", v, 20);
        ticks(5);
        rd(8'h0C, v); chk("R2 decrement", v, 15);

        // R3: cannot stop once running
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R3 enable reads 1", v & 1, 1);
        ticks(2);
        rd(8'h0C, v); chk("R3 still running", v, 13);

        // R8: ignored stray byte, then broken code
        wr(8'h08, 32'h12);
        rd(8'h00, v); chk("R8 stray ignored", v & 4, 0);
        wr(8'h08, 32'hAA); wr(8'h08, 32'h33);
        rd(8'h00, v); chk("R8 flag", v & 4, 4);
        rd(8'h0C, v); chk("R8 no reload", v, 13);
        chk("R4 irq from flag", irq, 1);

        // R7: write 0 keeps, write 1 clears
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R7 write0 keeps", v & 4, 4);
        wr(8'h00, 32'h4);
        rd(8'h00, v); chk("R7 write1 clears", v & 4, 0);
        chk("R7 irq low", irq, 0);

        // R6: warning at compare value
        wr(8'h14, 10);
        ticks(3);
        rd(8'h00, v); chk("R6 warn flag", v & 8, 8);
        chk("R6 irq", irq, 1);
        wr(8'h00, 32'h8);
        rd(8'h00, v); chk("R7 warn clear", v & 8, 0);

        // R4: expiry without reset-enable
        mark = req_cycles;
        ticks(10);
        rd(8'h0C, v); chk("R4 counter zero", v, 0);
        rd(8'h00, v); chk("R4 flag", v & 4, 4);
        chk("R4 irq", irq, 1);
        chk("R4 no reset req", req_cycles - mark, 0);
        wr(8'h00, 32'h4);

        // R9: out-of-window feed flags and still reloads
        wr(8'h18, 5); wr(8'h04, 20);
        feed();
        rd(8'h00, v); chk("R9 in-window ok", v & 4, 0);
        ticks(2);
        feed();
        rd(8'h00, v); chk("R9 flag", v & 4, 4);
        rd(8'h0C, v); chk("R9 reloaded", v, 20);
        wr(8'h00, 32'h4);

        // R10 / R11: protect sticky, guarded constant write
        wr(8'h00, 32'h10);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R10 protect sticky", v & 16, 16);
        wr(8'h04, 30);
        rd(8'h04, v); chk("R11 refused", v, 20);
        rd(8'h00, v); chk("R11 flag", v & 4, 4);
        wr(8'h00, 32'hC);
        ticks(16);
        wr(8'h00, 32'hC);
        wr(8'h04, 30);
        rd(8'h04, v); chk("R11 accepted", v, 30);
        rd(8'h00, v); chk("R11 no flag", v & 4, 0);

        // R10: lock armed only by a feed
        wr(8'h00, 32'h20);
        chk("R10 lock not yet", osc_locked, 0);
        feed();
        chk("R10 lock armed", osc_locked, 1);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R10 lock sticky", v & 32, 32);

        // R12: value register read-only, feed reads zero
        wr(8'h0C, 123);
        rd(8'h0C, v); chk("R12 value ro", v, 30);
        rd(8'h08, v); chk("R12 feed reads 0", v, 0);

        // R5: reset-enable sticky; expiry gives one request cycle
        wr(8'h00, 32'h2);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R5 sticky", v & 2, 2);
        ticks(20);
        wr(8'h00, 32'h8);
        mark = req_cycles; req_max = 0;
        ticks(10);
        @(negedge clk);
        chk("R5 one request", req_cycles - mark, 1);
        chk("R5 pulse width", req_max, 1);
        rd(8'h00, v); chk("R5 mode", v, 32'h37);
        chk("R5 irq quiet", irq, 0);

        // R2 / R6: random constants, tick counts and warning values
        for (int it = 0; it < 20; it++) begin
            int tc, k, w;
            tc = 5 + int'($urandom % 196);
            k  = int'($urandom % tc);
            w  = int'($urandom % (tc + 1));
            do_reset();
            wr(8'h14, w); wr(8'h18, 32'hFFFFFF); wr(8'h04, tc);
            wr(8'h00, 32'h1);
            feed();
            ticks(k);
            rd(8'h0C, v); chk("R2 random count", v, exp_cnt(tc, k));
            rd(8'h00, v); chk("R6 random warn", (v >> 3) & 1, 32'(exp_wint(tc, k, w)));
            chk("R4 random no flag", (v >> 2) & 1, 0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule